// File: doc/BRIEF.md
# Interrupt Pending Register with Output Gating

This block is a single 10-bit control and status word that a host processor reads and writes through a plain synchronous port (write strobe, write data, always-valid read data). It serves four interrupt channels. Each channel has one pending flag, one hardware event input and one active-high interrupt output. Channels 0 and 1 are raised by hardware and cleared by software. Channels 2 and 3 are raised by software and cleared by a hardware acknowledge. A write bit is an action bit only when it carries a 1. The same bit position reads back the channel's pending flag.

One more bit holds a disable request for the interrupt line of channel 0 toward the processor. A two-state gate machine applies that request only while channel 0's raw pending flag is low. Switching the line on or off therefore never cuts a pulse short and never reveals a pulse that is already under way. The gate states are GATE_SHUT and GATE_OPEN. The transition SHUT_TO_OPEN fires when the raw flag is low and the disable request is 0. The transition OPEN_TO_SHUT fires when the raw flag is low and the disable request is 1. The gate stays in its state whenever the raw flag is high.

Top module: `irq_pend_reg`

## Requirements
- R1: Reset clears all pending flags, sets the disable bit (bit 8) to 1 and puts the gate in GATE_SHUT. Read data is 0x100 and `irq_o` is 0 until the first event.
- R2: A rising edge on `evt_i[0]` or `evt_i[1]` sets the pending flag of channel 0 or channel 1. The flag shows on the next clock edge. An event level that is held high does not set the flag again.
- R3: A write with bit 9 = 1 clears channel 0, and a write with bit 7 = 1 clears channel 1. The matching output falls at the same edge.
- R4: A write with bit 6 = 1 sets channel 2, and a write with bit 5 = 1 sets channel 3.
- R5: A rising edge on `evt_i[2]` or `evt_i[3]` clears the pending flag of channel 2 or channel 3.
- R6: A 0 written to any of bits 9, 7, 6 or 5 leaves the matching flag unchanged.
- R7: Read data is {ch0, disable, ch1, ch2, ch3} in bits 9 down to 5.
- R8: Bits 4 to 0 always read 0, and writes to them have no effect.
- R9: When a setting action and a clearing action reach the same channel in the same cycle, the flag ends up set.
- R10: Every write loads bit 8 from the write data, and bit 8 reads back the value last written.
- R11: `irq_o[0]` is the channel 0 flag ANDed with GATE_OPEN. The gate changes state only at an edge where the channel 0 flag was low. The output therefore rises only when the flag rises and falls only when the flag falls.
- R12: `irq_o[3:1]` follow the pending flags of channels 3 to 1 directly, with no gating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write strobe for the control word |
| wdata_i | input | 10 | Write data |
| rdata_o | output | 10 | Pending flags and disable bit |
| evt_i | input | 4 | Hardware event or acknowledge, one per channel |
| irq_o | output | 4 | Interrupt outputs; bit 0 is gated |

## Verification
The table drives events alone, writes alone, and writes that coincide with events. This separates edge-triggered setting from level sensing and shows which of two colliding actions wins. Writes that carry only zeros in the action bits, or ones in the reserved bits, tell a true no-op apart from a write that disturbs the flags. The disable bit is toggled while the channel 0 flag is low, while it is high and hidden, and while it is high and visible. This separates a gate that waits for the flag to drop from one that switches immediately.

// File: rtl/irqpr_pkg.sv
package irqpr_pkg;
    localparam int NCH      = 4;
    localparam int REG_W    = 10;
    localparam int MASK_BIT = 8;
    localparam int N_HWSET  = 2;   // channels below this index are set by hardware

    typedef enum logic {
        GATE_SHUT = 1'b0,
        GATE_OPEN = 1'b1
    } gate_state_t;

    // bit position of each channel's action / status bit
    function automatic int chan_pos(input int ch);
        case (ch)
            0:       return 9;
            1:       return 7;
            2:       return 6;
            default: return 5;
        endcase
    endfunction
endpackage

// File: rtl/irqpr_edge.sv
module irqpr_edge #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] lvl_q;

    // tracks the input also during reset so a level held across reset is no edge
    always_ff @(posedge clk) begin
        lvl_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/irqpr_cell.sv
module irqpr_cell #(
    parameter bit HW_SETS = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_rise_i,
    input  logic sw_hit_i,
    output logic pend_o
);
    logic set_c;
    logic clr_c;

    generate
        if (HW_SETS) begin : g_hwset
            assign set_c = hw_rise_i;
            assign clr_c = sw_hit_i;
        end else begin : g_swset
            assign set_c = sw_hit_i;
            assign clr_c = hw_rise_i;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_o <= 1'b0;
        end else if (set_c) begin
            pend_o <= 1'b1;      // set has priority
        end else if (clr_c) begin
            pend_o <= 1'b0;
        end
    end
endmodule

// File: rtl/irqpr_gate.sv
module irqpr_gate
    import irqpr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    input  logic mask_i,
    output logic irq_o
);
    gate_state_t state_q;
    gate_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_SHUT: if (!raw_i && !mask_i) state_d = GATE_OPEN;  // SHUT_TO_OPEN
            GATE_OPEN: if (!raw_i &&  mask_i) state_d = GATE_SHUT;  // OPEN_TO_SHUT
            default:   state_d = GATE_SHUT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GATE_SHUT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        irq_o = raw_i && (state_q == GATE_OPEN);
    end
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
    import irqpr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] rdata_o,
    input  logic [NCH-1:0]   evt_i,
    output logic [NCH-1:0]   irq_o
);
    logic [NCH-1:0] rise;
    logic [NCH-1:0] pend;
    logic           mask_q;
    logic           unused_rsvd;

    assign unused_rsvd = ^wdata_i[4:0];

    irqpr_edge #(.W(NCH)) edge_i (
        .clk   (clk),
        .lvl_i (evt_i),
        .rise_o(rise)
    );

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            localparam int POS = chan_pos(g);
            irqpr_cell #(.HW_SETS(g < N_HWSET)) cell_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .hw_rise_i(rise[g]),
                .sw_hit_i (wr_en_i && wdata_i[POS]),
                .pend_o   (pend[g])
            );
            if (g != 0) begin : g_direct
                assign irq_o[g] = pend[g];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= 1'b1;
        end else if (wr_en_i) begin
            mask_q <= wdata_i[MASK_BIT];
        end
    end

    irqpr_gate gate_i (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i (pend[0]),
        .mask_i(mask_q),
        .irq_o (irq_o[0])
    );

    always_comb begin
        rdata_o           = '0;
        rdata_o[MASK_BIT] = mask_q;
        for (int i = 0; i < NCH; i++) begin
            rdata_o[chan_pos(i)] = pend[i];
        end
    end
endmodule

// File: rtl/irq_pend_reg_chk.sv
module irq_pend_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en_i,
    input logic [9:0] wdata_i,
    input logic [9:0] rdata_o,
    input logic [3:0] evt_i,
    input logic [3:0] irq_o
);
    // R11
    no_trunc_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o[0]) |-> !rdata_o[9]);

    // R11
    no_late_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o[0]) |-> $rose(rdata_o[9]));

    // R10
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> rdata_o[8] == $past(wdata_i[8]));

    // R4
    send_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wdata_i[6]) |=> rdata_o[6]);

    // R2
    hw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i[1] && !$past(evt_i[1])) |=> rdata_o[7]);

    // R12
    direct_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[3:1] == {rdata_o[5], rdata_o[6], rdata_o[7]});
endmodule

bind irq_pend_reg irq_pend_reg_chk chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en_i(wr_en_i),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o),
    .evt_i  (evt_i),
    .irq_o  (irq_o)
);

// File: tb/irq_pend_reg_tb_top.sv
module irq_pend_reg_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [9:0] wdata_i = '0;
    logic [3:0] evt_i = '0;
    logic [9:0] rdata_o;
    logic [3:0] irq_o;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    irq_pend_reg dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en_i(wr_en_i),
        .wdata_i(wdata_i),
        .rdata_o(rdata_o),
        .evt_i  (evt_i),
        .irq_o  (irq_o)
    );

    // {wr, wdata, evt, expected rdata, expected irq}
    localparam int NV = 25;
    localparam logic [28:0] VEC [0:NV-1] = '{
        {1'b0, 10'h000, 4'b0010, 10'h180, 4'b0010}, // R2 hw set ch1
        {1'b1, 10'h100, 4'b0000, 10'h180, 4'b0010}, // R6 zero actions
        {1'b1, 10'h180, 4'b0000, 10'h100, 4'b0000}, // R3 clear ch1
        {1'b1, 10'h140, 4'b0000, 10'h140, 4'b0100}, // R4 send ch2
        {1'b1, 10'h120, 4'b0000, 10'h160, 4'b1100}, // R4 send ch3
        {1'b0, 10'h000, 4'b0100, 10'h120, 4'b1000}, // R5 ack ch2
        {1'b0, 10'h000, 4'b0000, 10'h120, 4'b1000}, // R12 hold
        {1'b0, 10'h000, 4'b1000, 10'h100, 4'b0000}, // R5 ack ch3
        {1'b0, 10'h000, 4'b0001, 10'h300, 4'b0000}, // R11 set ch0, gate shut
        {1'b1, 10'h01F, 4'b0001, 10'h200, 4'b0000}, // R8 reserved, enable hidden
        {1'b1, 10'h200, 4'b0000, 10'h000, 4'b0000}, // R3 clear ch0
        {1'b0, 10'h000, 4'b0000, 10'h000, 4'b0000}, // R11 gate opens
        {1'b0, 10'h000, 4'b0001, 10'h200, 4'b0001}, // R11 visible pulse
        {1'b1, 10'h100, 4'b0001, 10'h300, 4'b0001}, // R11 disable mid pulse
        {1'b0, 10'h000, 4'b0001, 10'h300, 4'b0001}, // R11 pulse still full
        {1'b1, 10'h300, 4'b0001, 10'h100, 4'b0000}, // R3 clear ends pulse
        {1'b0, 10'h000, 4'b0000, 10'h100, 4'b0000}, // R11 gate shuts
        {1'b0, 10'h000, 4'b0001, 10'h300, 4'b0000}, // R11 masked pulse
        {1'b1, 10'h300, 4'b0001, 10'h100, 4'b0000}, // R2 held level no reset
        {1'b0, 10'h000, 4'b0000, 10'h100, 4'b0000}, // R7 idle
        {1'b1, 10'h180, 4'b0010, 10'h180, 4'b0010}, // R9 set beats clear
        {1'b1, 10'h180, 4'b0000, 10'h100, 4'b0000}, // R3 clear ch1
        {1'b1, 10'h140, 4'b0100, 10'h140, 4'b0100}, // R9 send beats ack
        {1'b0, 10'h000, 4'b0000, 10'h140, 4'b0100}, // R7 layout
        {1'b0, 10'h000, 4'b0100, 10'h100, 4'b0000}  // R5 ack ch2
    };

    task automatic check(input string req, input logic [9:0] exp_rd,
                         input logic [3:0] exp_irq);
        n_chk++;
        if (rdata_o !== exp_rd || irq_o !== exp_irq) begin
            n_err++;
            $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                     req, rdata_o, irq_o, exp_rd, exp_irq);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        check("R1 reset state", 10'h100, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 10'h100, 4'b0000);

        for (int i = 0; i < NV; i++) begin
            wr_en_i = VEC[i][28];
            wdata_i = VEC[i][27:18];
            evt_i   = VEC[i][17:14];
            @(negedge clk);
            check($sformatf("table row %0d", i), VEC[i][13:4], VEC[i][3:0]);
        end
        wr_en_i = 1'b0;
        evt_i   = '0;
        @(negedge clk);

        // R1: reset in mid operation restores the initial state
        evt_i = 4'b0011;
        @(negedge clk);
        check("R2 two hw sets", 10'h380, 4'b0010);
        rst_n = 1'b0;
        evt_i = '0;
        @(negedge clk);
        check("R1 mid-run reset", 10'h100, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: gate starts shut, so a ch0 event stays off the line
        evt_i = 4'b0001;
        @(negedge clk);
        check("R1 gate shut after reset", 10'h300, 4'b0000);
        evt_i = '0;

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule